// File: doc/BRIEF.md
# Configurable Multiprocessor Serial Transmitter

This block sends asynchronous serial frames on one line. The line stays high when nothing is being sent. A character arrives over a valid/ready handshake. A flag travels with it and marks the character as an address or as data. The block captures the character and the frame configuration in the cycle the handshake completes. It then sends the frame one element per baud tick. The baud tick is a single-cycle strobe that comes from outside the block.

The frame format is chosen at run time by these controls:

- the character length, from 1 to 8 bits;
- parity on or off, and its sense;
- one or two stop bits;
- the multiprocessor mode.

The mode decides how an address is marked:

- In address-bit mode, each frame carries one extra bit after the data. This bit tells an address character apart from a data character.
- In idle-line mode, no extra bit is sent. Instead, an address character is preceded by a quiet gap of several bit times with the line held high.

Top module: `mp_serial_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx` is 1 and `in_ready` is 1.
- R2: A frame starts with one low start bit. Then come the data bits, least significant first. Their count is `cfg_len`+1, so code 000 sends 1 bit and code 111 sends 8 bits. Data bits above that count are not sent.
- R3: When `cfg_par_en` is 1, one parity bit follows the data bits (and the address/data bit, if present). With `cfg_par_even`=1, the number of ones across the data bits, the address/data bit and the parity bit is even. With `cfg_par_even`=0, that number is odd. When `cfg_par_en` is 0, no parity bit is sent.
- R4: The frame ends with high stop bits: one when `cfg_two_stop`=0, and two when `cfg_two_stop`=1.
- R5: When `cfg_addr_mode`=1 (address-bit mode), one bit is sent directly after the data bits. It equals `in_is_addr`: 1 marks an address and 0 marks data.
- R6: When `cfg_addr_mode`=0 (idle-line mode), no address/data bit is sent.
  - An address character (`in_is_addr`=1) is preceded by a gap in which `tx` stays 1 for GAP_BITS tick intervals, counted from acceptance. GAP_BITS defaults to 11.
  - A data character starts with no gap.
- R7: The first frame element (the gap or the start bit) appears on `tx` in the cycle after acceptance. After that, each element ends at a `tick` pulse, and `tx` changes at no other time.
- R8: `in_ready` is 0 from the cycle after acceptance until the cycle after the tick that ends the last stop bit. The data and configuration are captured at acceptance, so changes to these inputs during a frame have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Baud strobe; one element ends per pulse |
| cfg_len | input | 3 | Character length minus one |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_even | input | 1 | Parity sense: 1 even, 0 odd |
| cfg_two_stop | input | 1 | Stop bits: 0 one, 1 two |
| cfg_addr_mode | input | 1 | 1 address-bit mode, 0 idle-line mode |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Transmitter idle, ready to accept |
| in_data | input | 8 | Character bits |
| in_is_addr | input | 1 | Character is an address |
| tx | output | 1 | Serial line |

## Verification
The line and `in_ready` are the only outputs, and both are decoded from state registers with no further flop. After an accepting clock edge, the first frame element and the drop of `in_ready` are therefore due in the following cycle. Each later element is due in the cycle after the tick that ends the previous one, and `in_ready` returns in the cycle after the tick that ends the final stop bit. The reference model keeps one queue entry per element. It pushes the entries on the accepting edge and pops one entry on each tick edge. Both outputs are compared with the head of this queue at every falling edge, half a cycle after the state has settled. Tick spacings of 1, 4 and 7 cycles exercise the timing at several phases.

// File: rtl/mp_serial_tx.sv
module mp_serial_tx #(
  parameter int DATA_W   = 8,
  parameter int GAP_BITS = 11
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic [$clog2(DATA_W)-1:0] cfg_len,
  input  logic                      cfg_par_en,
  input  logic                      cfg_par_even,
  input  logic                      cfg_two_stop,
  input  logic                      cfg_addr_mode,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [DATA_W-1:0]         in_data,
  input  logic                      in_is_addr,
  output logic                      tx
);
  localparam int FRAME_W = DATA_W + 5;
  localparam int CNT_W   = $clog2(FRAME_W) + 1;
  localparam int GAP_W   = $clog2(GAP_BITS + 1);

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_SEND} st_t;
  st_t st;

  logic [FRAME_W-1:0] sh, frame_c;
  logic [CNT_W-1:0]   left, len_c;
  logic [GAP_W-1:0]   gap;
  logic               accept, need_gap;

  assign in_ready = (st == S_IDLE);
  assign accept   = in_valid && in_ready;
  assign need_gap = !cfg_addr_mode && in_is_addr;
  assign tx       = (st == S_SEND) ? sh[0] : 1'b1;

  always_comb begin
    int   pos;
    int   nbits;
    logic par;
    frame_c    = '1;
    frame_c[0] = 1'b0;
    par        = 1'b0;
    nbits      = int'(cfg_len) + 1;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nbits) begin
        frame_c[1+i] = in_data[i];
        par          = par ^ in_data[i];
      end
    end
    pos = 1 + nbits;
    if (cfg_addr_mode) begin
      frame_c[pos] = in_is_addr;
      par          = par ^ in_is_addr;
      pos          = pos + 1;
    end
    if (cfg_par_en) begin
      frame_c[pos] = par ^ !cfg_par_even;
      pos          = pos + 1;
    end
    pos   = pos + (cfg_two_stop ? 2 : 1);
    len_c = CNT_W'(pos - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      sh   <= '1;
      left <= '0;
      gap  <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          sh   <= frame_c;
          left <= len_c;
          gap  <= GAP_W'(GAP_BITS - 1);
          st   <= need_gap ? S_GAP : S_SEND;
        end
        S_GAP: if (tick) begin
          if (gap == '0) st <= S_SEND;
          else           gap <= gap - 1'b1;
        end
        S_SEND: if (tick) begin
          if (left == '0) st <= S_IDLE;
          else begin
            sh   <= {1'b1, sh[FRAME_W-1:1]};
            left <= left - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> tx);

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !need_gap) |=> (!tx && !in_ready));

  // R6
  gap_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && need_gap) |=> (tx && !in_ready));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !accept) |=> $stable(tx));

  // R4
  stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(tx));
endmodule

// File: tb/sim_mp_serial_tx.sv
`timescale 1ns/1ps
module sim_mp_serial_tx;
  localparam int GAP_BITS = 11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] cfg_len = '0;
  logic       cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_two_stop = 1'b0, cfg_addr_mode = 1'b0;
  logic       in_valid = 1'b0, in_is_addr = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, tx;

  int    checks = 0, fails = 0, cycles = 0, tper = 4, tcnt = 0;
  string cur_req = "R1";
  int    q[$];

  always #4 clk = ~clk;

  mp_serial_tx #(.DATA_W(8), .GAP_BITS(GAP_BITS)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_two_stop(cfg_two_stop), .cfg_addr_mode(cfg_addr_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_is_addr(in_is_addr), .tx(tx));

  always @(negedge clk) begin
    tcnt = (tcnt + 1 >= tper) ? 0 : tcnt + 1;
    tick = (tcnt == 0);
  end

  task automatic push_frame();
    int ones;
    int n;
    ones = 0;
    n = int'(cfg_len) + 1;
    if (!cfg_addr_mode && in_is_addr)
      for (int g = 0; g < GAP_BITS; g++) q.push_back(1);
    q.push_back(0);
    for (int i = 0; i < n; i++) begin
      q.push_back(int'(in_data[i]));
      ones += int'(in_data[i]);
    end
    if (cfg_addr_mode) begin
      q.push_back(int'(in_is_addr));
      ones += int'(in_is_addr);
    end
    if (cfg_par_en) q.push_back(cfg_par_even ? ones % 2 : 1 - ones % 2);
    q.push_back(1);
    if (cfg_two_stop) q.push_back(1);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) q.delete();
    else if (q.size() == 0) begin
      if (in_valid) push_frame();
    end else if (tick) void'(q.pop_front());
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(cur_req, int'(tx), (q.size() == 0) ? 1 : q[0], "tx");
      check(cur_req, int'(in_ready), (q.size() == 0) ? 1 : 0, "in_ready");
    end
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic send(input logic [7:0] d, input logic a, input logic [2:0] len,
                      input logic pe, input logic ev, input logic two,
                      input logic mode, input string tag);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    cur_req = tag;
    in_data = d; in_is_addr = a; cfg_len = len; cfg_par_en = pe;
    cfg_par_even = ev; cfg_two_stop = two; cfg_addr_mode = mode;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    in_data = ~d; in_is_addr = ~a; cfg_len = ~len; cfg_par_en = ~pe;
    cfg_par_even = ~ev; cfg_two_stop = ~two; cfg_addr_mode = ~mode;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(tx), 1, "reset tx");
    check("R1", int'(in_ready), 1, "reset in_ready");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    send(8'hA5, 1'b0, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    send(8'hFF, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    send(8'h3C, 1'b0, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    send(8'h5B, 1'b0, 3'd7, 1'b1, 1'b1, 1'b0, 1'b0, "R3");
    send(8'h5B, 1'b0, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
    send(8'h00, 1'b0, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
    send(8'h96, 1'b0, 3'd7, 1'b0, 1'b0, 1'b1, 1'b0, "R4");
    send(8'h01, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R4");
    send(8'h42, 1'b1, 3'd7, 1'b0, 1'b0, 1'b0, 1'b1, "R5");
    send(8'h42, 1'b0, 3'd7, 1'b0, 1'b0, 1'b0, 1'b1, "R5");
    send(8'h07, 1'b1, 3'd2, 1'b1, 1'b1, 1'b1, 1'b1, "R5");
    send(8'h07, 1'b1, 3'd2, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
    send(8'hC3, 1'b1, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    send(8'hC3, 1'b0, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    send(8'h11, 1'b1, 3'd3, 1'b1, 1'b1, 1'b1, 1'b0, "R6");
    tper = 7;
    send(8'h6D, 1'b0, 3'd6, 1'b1, 1'b0, 1'b1, 1'b1, "R7");
    send(8'h6D, 1'b1, 3'd6, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
    tper = 1;
    send(8'hB2, 1'b1, 3'd7, 1'b1, 1'b1, 1'b1, 1'b1, "R7");
    send(8'hB2, 1'b1, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    tper = 4;
    send(8'hE8, 1'b0, 3'd7, 1'b1, 1'b1, 1'b0, 1'b1, "R8");
    for (int k = 0; k < 40; k++) begin
      tper = 1 + int'($urandom_range(0, 5));
      send(8'($urandom), 1'($urandom), 3'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), "R8");
    end
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    repeat (5) @(negedge clk);
    cur_req = "R1";
    check("R1", int'(tx), 1, "final idle tx");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule